// File: doc/BRIEF.md
# Peak Voltage Drop Termination Detector

This block watches the battery cell voltage during fast charge and raises a one-cycle terminate pulse when the voltage has fallen a set number of ADC steps below the highest sample seen so far. A slow sample tick, nominally one every 34 s, opens a burst of ADC conversions. Each conversion is marked by a strobe. The burst is summed and shifted right to give one averaged sample: 16 conversions in the negative-delta-V mode and 32 in the peak-detect mode.

A running maximum of the averaged samples is kept. Each new sample is compared against that maximum with a drop threshold that depends on the mode. The test only runs while the sample lies strictly inside a window of 0.4 to 0.8 of ADC full scale. A start-of-charge hold-off flag masks the negative-delta-V test. A fast-charge-start pulse clears the peak, and the next in-window sample is loaded as the new peak without being tested. The current average and the peak are brought out for debug. The charge state machine upstream consumes the pulse.

Top module: `pkdrop_term_det`

## Requirements
- R1: After reset, `term_pulse` is 0, `avg_out` and `peak_out` are 0, and `peak_valid` is 0.
- R2: The mode input `vmode` uses these encodings: 2'b01 selects negative-delta-V with 16-conversion bursts, and 2'b10 selects peak-detect with 32-conversion bursts. A `sample_tick` in either mode starts a burst. One cycle after the clock edge that accepts the last `conv_valid` conversion, `avg_out` equals floor(sum of the codes / burst length). Cycles without `conv_valid` do not count toward the burst.
- R3: When `vmode` is 2'b00 or 2'b11, voltage termination is disabled. A `sample_tick` starts no burst, `avg_out` does not change, and no terminate pulse occurs.
- R4: The first in-window sample after reset or after `charge_start` is loaded into `peak_out` and sets `peak_valid`. That sample is never tested and raises no terminate pulse.
- R5: `peak_out` follows the maximum of all in-window samples taken since the last `charge_start`.
- R6: In mode 2'b01, if `peak_out` minus the sample is at least DROP_NDV (default 4 LSB), `term_pulse` is high for exactly one cycle. That cycle is the one after `avg_out` takes the sample.
- R7: In mode 2'b10, the same test uses DROP_PVD (default 2 LSB). A drop one LSB smaller than the threshold does not terminate.
- R8: A sample is in the window only if WIN_LO < sample < WIN_HI. With the defaults, WIN_LO = floor(0.4·1024) = 409 and WIN_HI = floor(0.8·1024) = 819. A sample outside the window neither updates the peak nor can terminate.
- R9: While `holdoff` is high, termination in mode 2'b01 is suppressed. Termination in mode 2'b10 is not affected, and peak tracking continues in both modes.
- R10: `charge_start` clears `peak_out` and `peak_valid` and abandons any burst in progress. Conversions that follow it produce no sample until the next tick.
- R11: A `sample_tick` that arrives during a burst discards the partial sum and restarts the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vmode | input | 2 | Termination mode: 00/11 off, 01 negative-delta-V, 10 peak-detect |
| sample_tick | input | 1 | Starts a new averaging burst |
| conv_valid | input | 1 | Strobe: `conv_code` holds a fresh conversion |
| conv_code | input | ADC_W | ADC conversion code, VCC full scale |
| charge_start | input | 1 | Fast-charge-start pulse; clears the peak |
| holdoff | input | 1 | Start-of-charge hold-off active |
| term_pulse | output | 1 | One-cycle termination request |
| avg_out | output | ADC_W | Most recent averaged sample |
| peak_out | output | ADC_W | Running maximum of valid samples |
| peak_valid | output | 1 | Peak register holds a sample |

## Verification
Rising series of samples in both modes are fed with varying conversion spread and strobe gaps. These check the truncating average and that the peak follows the maximum with no false pulses. Descending series cross the drop threshold one LSB at a time, which separates the two thresholds and shows the pulse firing on every sample past the limit. Samples placed exactly on and just inside the window edges show which samples are ignored. A hold-off run, two disabled modes, a mid-burst restart and a mid-burst charge start separate the gating paths from the arithmetic.

// File: rtl/pkdrop_pkg.sv
package pkdrop_pkg;

  typedef enum logic [1:0] {
    VM_OFF = 2'b00,
    VM_NDV = 2'b01,
    VM_PVD = 2'b10
  } vmode_e;

  function automatic vmode_e decode_mode(input logic [1:0] raw);
    case (raw)
      2'b01:   decode_mode = VM_NDV;
      2'b10:   decode_mode = VM_PVD;
      default: decode_mode = VM_OFF;
    endcase
  endfunction

  function automatic int unsigned burst_log2(input vmode_e m,
                                             input int unsigned ndv_l2,
                                             input int unsigned pvd_l2);
    burst_log2 = (m == VM_PVD) ? pvd_l2 : ndv_l2;
  endfunction

  function automatic logic inside_window(input int unsigned v,
                                         input int unsigned lo,
                                         input int unsigned hi);
    inside_window = (v > lo) && (v < hi);
  endfunction

  function automatic logic drop_reached(input int unsigned peak,
                                        input int unsigned v,
                                        input int unsigned thr);
    drop_reached = (peak >= v) && ((peak - v) >= thr);
  endfunction

endpackage

// File: rtl/pkdrop_burst_avg.sv
module pkdrop_burst_avg
  import pkdrop_pkg::*;
#(
  parameter int unsigned ADC_W    = 10,
  parameter int unsigned NDV_LOG2 = 4,
  parameter int unsigned PVD_LOG2 = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             sample_tick,
  input  vmode_e           mode_in,
  input  logic             conv_valid,
  input  logic [ADC_W-1:0] conv_code,
  output logic             busy,
  output logic             smp_valid,
  output logic [ADC_W-1:0] smp_value,
  output vmode_e           smp_mode
);

  localparam int unsigned MAXL  = (NDV_LOG2 > PVD_LOG2) ? NDV_LOG2 : PVD_LOG2;
  localparam int unsigned ACC_W = ADC_W + MAXL;
  localparam int unsigned CNT_W = MAXL + 1;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_next;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_idx;
  logic [ACC_W-1:0] shifted;
  vmode_e           mode_q;
  logic             tick_ok;
  logic             last_conv;

  assign tick_ok   = sample_tick && (mode_in != VM_OFF);
  assign acc_next  = acc_q + {{(ACC_W-ADC_W){1'b0}}, conv_code};
  assign last_idx  = CNT_W'((1 << burst_log2(mode_q, NDV_LOG2, PVD_LOG2)) - 1);
  assign last_conv = busy && conv_valid && (cnt_q == last_idx);
  assign shifted   = acc_next >> burst_log2(mode_q, NDV_LOG2, PVD_LOG2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q     <= '0;
      cnt_q     <= '0;
      busy      <= 1'b0;
      mode_q    <= VM_OFF;
      smp_valid <= 1'b0;
      smp_value <= '0;
      smp_mode  <= VM_OFF;
    end else begin
      smp_valid <= 1'b0;
      if (abort) begin
        busy <= 1'b0;
      end else if (tick_ok) begin
        busy   <= 1'b1;
        acc_q  <= '0;
        cnt_q  <= '0;
        mode_q <= mode_in;
      end else if (busy && conv_valid) begin
        if (last_conv) begin
          busy      <= 1'b0;
          smp_valid <= 1'b1;
          smp_value <= shifted[ADC_W-1:0];
          smp_mode  <= mode_q;
        end else begin
          acc_q <= acc_next;
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pkdrop_peak_track.sv
module pkdrop_peak_track
  import pkdrop_pkg::*;
#(
  parameter int unsigned ADC_W    = 10,
  parameter int unsigned DROP_NDV = 4,
  parameter int unsigned DROP_PVD = 2,
  parameter int unsigned WIN_LO   = 409,
  parameter int unsigned WIN_HI   = 819
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             smp_valid,
  input  logic [ADC_W-1:0] smp_value,
  input  vmode_e           smp_mode,
  input  logic             holdoff,
  output logic [ADC_W-1:0] peak_q,
  output logic             peak_valid_q,
  output logic             term_q,
  output logic             win_ok,
  output logic             hit
);

  int unsigned thr;
  logic        allow;

  assign thr    = (smp_mode == VM_PVD) ? DROP_PVD : DROP_NDV;
  assign win_ok = inside_window(int'(smp_value), WIN_LO, WIN_HI);
  assign hit    = peak_valid_q && drop_reached(int'(peak_q), int'(smp_value), thr);
  assign allow  = (smp_mode == VM_PVD) || ((smp_mode == VM_NDV) && !holdoff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      peak_q       <= '0;
      peak_valid_q <= 1'b0;
      term_q       <= 1'b0;
    end else begin
      term_q <= 1'b0;
      if (clear) begin
        peak_q       <= '0;
        peak_valid_q <= 1'b0;
      end else if (smp_valid && win_ok) begin
        if (!peak_valid_q) begin
          peak_q       <= smp_value;
          peak_valid_q <= 1'b1;
        end else begin
          if (smp_value > peak_q) peak_q <= smp_value;
          term_q <= hit && allow;
        end
      end
    end
  end

endmodule

// File: rtl/pkdrop_term_det.sv
module pkdrop_term_det
  import pkdrop_pkg::*;
#(
  parameter int unsigned ADC_W    = 10,
  parameter int unsigned NDV_LOG2 = 4,
  parameter int unsigned PVD_LOG2 = 5,
  parameter int unsigned DROP_NDV = 4,
  parameter int unsigned DROP_PVD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       vmode,
  input  logic             sample_tick,
  input  logic             conv_valid,
  input  logic [ADC_W-1:0] conv_code,
  input  logic             charge_start,
  input  logic             holdoff,
  output logic             term_pulse,
  output logic [ADC_W-1:0] avg_out,
  output logic [ADC_W-1:0] peak_out,
  output logic             peak_valid
);

  localparam int unsigned FULL   = 1 << ADC_W;
  localparam int unsigned WIN_LO = (FULL * 2) / 5;
  localparam int unsigned WIN_HI = (FULL * 4) / 5;

  vmode_e           mode_dec;
  logic             burst_busy;
  logic             smp_valid;
  logic [ADC_W-1:0] smp_value;
  vmode_e           smp_mode;
  logic             win_ok;
  logic             drop_hit;

  assign mode_dec = decode_mode(vmode);

  pkdrop_burst_avg #(
    .ADC_W   (ADC_W),
    .NDV_LOG2(NDV_LOG2),
    .PVD_LOG2(PVD_LOG2)
  ) u_avg (
    .clk        (clk),
    .rst_n      (rst_n),
    .abort      (charge_start),
    .sample_tick(sample_tick),
    .mode_in    (mode_dec),
    .conv_valid (conv_valid),
    .conv_code  (conv_code),
    .busy       (burst_busy),
    .smp_valid  (smp_valid),
    .smp_value  (smp_value),
    .smp_mode   (smp_mode)
  );

  pkdrop_peak_track #(
    .ADC_W   (ADC_W),
    .DROP_NDV(DROP_NDV),
    .DROP_PVD(DROP_PVD),
    .WIN_LO  (WIN_LO),
    .WIN_HI  (WIN_HI)
  ) u_peak (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (charge_start),
    .smp_valid   (smp_valid),
    .smp_value   (smp_value),
    .smp_mode    (smp_mode),
    .holdoff     (holdoff),
    .peak_q      (peak_out),
    .peak_valid_q(peak_valid),
    .term_q      (term_pulse),
    .win_ok      (win_ok),
    .hit         (drop_hit)
  );

  assign avg_out = smp_value;

endmodule

// File: rtl/pkdrop_term_det_chk.sv
module pkdrop_term_det_chk #(
  parameter int unsigned ADC_W  = 10,
  parameter int unsigned WIN_LO = 409,
  parameter int unsigned WIN_HI = 819
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       vmode,
  input logic             sample_tick,
  input logic             charge_start,
  input logic             holdoff,
  input logic             term_pulse,
  input logic [ADC_W-1:0] peak_out,
  input logic             peak_valid,
  input logic             burst_busy,
  input logic             smp_valid,
  input logic [1:0]       smp_mode
);

  a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    term_pulse |=> !term_pulse);

  a_r6_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    term_pulse |-> $past(smp_valid));

  a_r4_first_untested: assert property (@(posedge clk) disable iff (!rst_n)
    term_pulse |-> $past(peak_valid));

  a_r9_holdoff_masks_ndv: assert property (@(posedge clk) disable iff (!rst_n)
    (term_pulse && $past(holdoff)) |-> ($past(smp_mode) == 2'b10));

  a_r3_off_no_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && !burst_busy && !charge_start && (vmode == 2'b00 || vmode == 2'b11))
      |=> !burst_busy);

  a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    charge_start |=> (!peak_valid && peak_out == '0 && !burst_busy));

  a_r5_peak_never_falls: assert property (@(posedge clk) disable iff (!rst_n)
    (peak_valid && !charge_start) |=> (peak_valid && peak_out >= $past(peak_out)));

  a_r8_peak_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    peak_valid |-> (int'(peak_out) > WIN_LO && int'(peak_out) < WIN_HI));

endmodule

bind pkdrop_term_det pkdrop_term_det_chk #(
  .ADC_W (ADC_W),
  .WIN_LO(WIN_LO),
  .WIN_HI(WIN_HI)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .vmode       (vmode),
  .sample_tick (sample_tick),
  .charge_start(charge_start),
  .holdoff     (holdoff),
  .term_pulse  (term_pulse),
  .peak_out    (peak_out),
  .peak_valid  (peak_valid),
  .burst_busy  (burst_busy),
  .smp_valid   (smp_valid),
  .smp_mode    (smp_mode)
);

// File: tb/sim_pkdrop_term_det.sv
module sim_pkdrop_term_det;

  localparam int W = 10;
  localparam int DROP_N = 4;
  localparam int DROP_P = 2;
  localparam int LO = 409;
  localparam int HI = 819;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   vmode = 2'b00;
  logic         sample_tick = 1'b0;
  logic         conv_valid = 1'b0;
  logic [W-1:0] conv_code = '0;
  logic         charge_start = 1'b0;
  logic         holdoff = 1'b0;
  logic         term_pulse;
  logic [W-1:0] avg_out;
  logic [W-1:0] peak_out;
  logic         peak_valid;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int m_peak = 0;
  bit m_pv = 1'b0;
  int m_avg = 0;

  always #4 clk = ~clk;

  pkdrop_term_det u0 (
    .clk(clk), .rst_n(rst_n), .vmode(vmode), .sample_tick(sample_tick),
    .conv_valid(conv_valid), .conv_code(conv_code), .charge_start(charge_start),
    .holdoff(holdoff), .term_pulse(term_pulse), .avg_out(avg_out),
    .peak_out(peak_out), .peak_valid(peak_valid)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start_charge();
    @(negedge clk); charge_start = 1'b1;
    @(negedge clk); charge_start = 1'b0;
    m_peak = 0; m_pv = 1'b0;
    chk("R10 peak cleared", peak_out, 0);
    chk("R10 valid cleared", peak_valid, 0);
  endtask

  // one burst: codes base + (i mod (spread+1)); optional strobe gaps
  task automatic burst(input logic [1:0] m, input int base, input int spread,
                       input bit gap, input string req);
    int n;
    int sum;
    int exp_term;
    int a;
    bit on;
    on = (m == 2'b01) || (m == 2'b10);
    n = (m == 2'b10) ? 32 : 16;
    sum = 0;
    @(negedge clk); vmode = m; sample_tick = 1'b1;
    @(negedge clk); sample_tick = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (gap && (i % 3 == 2)) begin
        conv_valid = 1'b0;
        @(negedge clk);
      end
      conv_valid = 1'b1;
      conv_code = W'(base + (i % (spread + 1)));
      sum += base + (i % (spread + 1));
      @(negedge clk);
    end
    conv_valid = 1'b0;
    exp_term = 0;
    if (on) begin
      a = sum / n;
      m_avg = a;
      if (a > LO && a < HI) begin
        if (!m_pv) begin
          m_peak = a; m_pv = 1'b1;
        end else begin
          if ((m_peak - a) >= ((m == 2'b10) ? DROP_P : DROP_N) &&
              (m == 2'b10 || !holdoff)) exp_term = 1;
          if (a > m_peak) m_peak = a;
        end
      end
    end
    chk({req, " avg"}, avg_out, m_avg);
    chk({req, " no early pulse"}, term_pulse, 0);
    @(negedge clk);
    chk({req, " term"}, term_pulse, exp_term);
    chk({req, " peak"}, peak_out, m_peak);
    chk({req, " peak valid"}, peak_valid, m_pv);
    @(negedge clk);
    chk({req, " pulse ends"}, term_pulse, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got hang expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 term", term_pulse, 0);
    chk("R1 avg", avg_out, 0);
    chk("R1 peak", peak_out, 0);
    chk("R1 valid", peak_valid, 0);
    rst_n = 1'b1;

    // R2 R4 R5 rising sweeps in both modes, varied spread and gaps
    for (int md = 1; md <= 2; md++) begin
      start_charge();
      for (int k = 0; k < 12; k++)
        burst(2'(md), 420 + k * 31, k % 8, bit'(k % 2), "R2 R5 rising");
    end

    // R6 descending one LSB per sample in NDV mode
    start_charge();
    for (int k = 0; k < 7; k++) burst(2'b01, 700 - k, 0, 1'b0, "R6 ndv drop");
    // R7 descending in PVD mode
    start_charge();
    for (int k = 0; k < 5; k++) burst(2'b10, 600 - k, 0, 1'b1, "R7 pvd drop");

    // R8 window edges: peak 700 then on-edge samples ignored, inside accepted
    start_charge();
    burst(2'b01, LO, 0, 1'b0, "R8 low edge not loaded");
    burst(2'b01, 700, 0, 1'b0, "R4 first load");
    burst(2'b01, LO, 0, 1'b0, "R8 low edge ignored");
    burst(2'b01, HI, 0, 1'b0, "R8 high edge ignored");
    burst(2'b01, HI - 1, 0, 1'b0, "R8 inside top");
    burst(2'b01, LO + 1, 0, 1'b0, "R8 inside bottom");

    // R9 hold-off masks NDV only
    start_charge();
    holdoff = 1'b1;
    burst(2'b01, 650, 0, 1'b0, "R9 load");
    burst(2'b01, 640, 0, 1'b0, "R9 ndv masked");
    burst(2'b10, 630, 0, 1'b0, "R9 pvd fires");
    holdoff = 1'b0;
    burst(2'b01, 620, 0, 1'b0, "R9 ndv after holdoff");

    // R3 disabled modes
    burst(2'b00, 500, 3, 1'b0, "R3 mode 00");
    burst(2'b11, 300, 3, 1'b0, "R3 mode 11");

    // R11 restart on tick mid-burst
    @(negedge clk); vmode = 2'b01; sample_tick = 1'b1;
    @(negedge clk); sample_tick = 1'b0;
    for (int i = 0; i < 5; i++) begin
      conv_valid = 1'b1; conv_code = W'(1000); @(negedge clk);
    end
    conv_valid = 1'b0;
    burst(2'b01, 612, 2, 1'b0, "R11 restart");

    // R10 charge start abandons a burst
    @(negedge clk); vmode = 2'b10; sample_tick = 1'b1;
    @(negedge clk); sample_tick = 1'b0;
    for (int i = 0; i < 4; i++) begin
      conv_valid = 1'b1; conv_code = W'(500); @(negedge clk);
    end
    conv_valid = 1'b0;
    start_charge();
    for (int i = 0; i < 40; i++) begin
      conv_valid = 1'b1; conv_code = W'(450); @(negedge clk);
    end
    conv_valid = 1'b0;
    @(negedge clk);
    chk("R10 burst abandoned avg", avg_out, m_avg);
    chk("R10 burst abandoned valid", peak_valid, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule